// File: doc/BRIEF.md
# Prescaled Single-Channel PWM Timer

This block produces one pulse-width-modulated output from a small register file reached through a simple valid/write/address/data port. A power-of-two prescaler slows the clock into ticks. An up-counter advances on each tick, returns to zero after it reaches the reload value, and is compared against a compare value to shape the waveform. A polarity bit can invert the result.

Register writes obey access rules that follow the enable state. Shape settings (prescale exponent and polarity) are changed only while the timer is off. Period and compare values are changed only while it is on. Each accepted period or compare write raises a sticky acknowledge flag a fixed number of cycles later. Software clears these flags through a separate clear register. Enabling does not start counting: an explicit start bit is needed.

Top module: `lpt_pwm_timer`

## Requirements
- R1: After reset every register at addresses 0 to 5 reads 0 and `pwm_out` is 0.
- R2: Address map. 0 = control: bit0 enable, bit1 start (it reads back 1 while the counter runs). 1 = shape: bits[2:0] prescale exponent, bit3 polarity. 2 = reload value. 3 = compare value. 4 = flags: bit0 reload-acknowledge, bit1 compare-acknowledge. 5 = flag clear. A read returns the addressed value in the same cycle. Written values read back unchanged.
- R3: A write to the shape register while enable is 1 has no effect.
- R4: A write to the reload or compare register while enable is 0 has no effect and raises no flag.
- R5: An accepted reload or compare write sets its flag. The flag reads 0 after the accepting clock edge and after the next edge, and reads 1 from the second edge after the accepting edge.
- R6: Writing 1 to a bit of the clear register clears the matching flag. A 0 bit leaves that flag unchanged.
- R7: The counter runs only after a control write with bit0 and bit1 both 1. A start bit written with bit0 at 0 is ignored.
- R8: With prescale exponent 0, reload R and compare C, the period is R+1 cycles and the output is 1 for R−C cycles of each period when C<R. When C≥R the output stays inactive.
- R9: With prescale exponent n, each counter step lasts 2^n clock cycles, so both the period and the active time scale by 2^n.
- R10: Polarity 1 inverts the waveform. While the counter is stopped, `pwm_out` equals the polarity bit.
- R11: Reload and compare values written while the counter runs take effect at the next counter wrap, not at once.
- R12: Writing control with bit0 at 0 clears enable and stops the counter, and `pwm_out` returns to the polarity bit at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| pwm_out | output | 1 | Waveform output |

## Verification
Read data follows the address in the same cycle, and a write shows in readback after its accepting edge. The bench therefore samples one nanosecond after the negative edge that follows the write. Acknowledge flags are due two edges after the accepting edge, so the bench samples them after that edge and also after the two edges before it, to prove they were not early. Waveform results are counted over a whole number of periods, starting from the first state after the start write. Because the counter begins from zero with the prescaler cleared, the expected active-cycle count does not depend on the phase. The deferred compare update is checked one edge after the write, while the old compare value still governs the output, and again after the wrap.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
   localparam logic [ADDR_W-1:0] ADR_SHAPE  = 3'd1;
   localparam logic [ADDR_W-1:0] ADR_RELOAD = 3'd2;
   localparam logic [ADDR_W-1:0] ADR_CMP    = 3'd3;
   localparam logic [ADDR_W-1:0] ADR_FLAGS  = 3'd4;
   localparam logic [ADDR_W-1:0] ADR_CLEAR  = 3'd5;

   localparam int CTRL_EN    = 0;
   localparam int CTRL_START = 1;

   localparam int NFLAGS     = 2;
   localparam int FLG_RELOAD = 0;
   localparam int FLG_CMP    = 1;
endpackage

// File: rtl/lpt_regs.sv
module lpt_regs
   import lpt_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 16,
   parameter int PRESC_W     = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_valid,
   input  logic               bus_write,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               enable,
   output logic               run,
   output logic [PRESC_W-1:0] presc,
   output logic               pol,
   output logic [CNT_W-1:0]   reload_sh,
   output logic [CNT_W-1:0]   cmp_sh
);
   localparam int POL_BIT = PRESC_W;

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (POL_BIT >= DATA_W) begin : g_bad_pol
      $error("shape fields do not fit the data width");
   end

   logic              wr_en;
   logic [NFLAGS-1:0] accepted;
   logic [NFLAGS-1:0] flags;

   assign wr_en              = bus_valid & bus_write;
   assign accepted[FLG_RELOAD] = wr_en && (bus_addr == ADR_RELOAD) && enable;
   assign accepted[FLG_CMP]    = wr_en && (bus_addr == ADR_CMP) && enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable <= 1'b0;
         run    <= 1'b0;
      end else if (wr_en && bus_addr == ADR_CTRL) begin
         enable <= bus_wdata[CTRL_EN];
         run    <= bus_wdata[CTRL_EN] & (bus_wdata[CTRL_START] | run);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         presc <= '0;
         pol   <= 1'b0;
      end else if (wr_en && bus_addr == ADR_SHAPE && !enable) begin
         presc <= bus_wdata[PRESC_W-1:0];
         pol   <= bus_wdata[POL_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_sh <= '0;
         cmp_sh    <= '0;
      end else begin
         if (accepted[FLG_RELOAD]) reload_sh <= bus_wdata[CNT_W-1:0];
         if (accepted[FLG_CMP])    cmp_sh    <= bus_wdata[CNT_W-1:0];
      end
   end

   for (genvar f = 0; f < NFLAGS; f++) begin : g_flag
      logic [SYNC_STAGES-1:0] pipe;
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= accepted[f];
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[SYNC_STAGES-2:0], accepted[f]};
         end
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[f] <= 1'b0;
         else if (pipe[SYNC_STAGES-1])
            flags[f] <= 1'b1;
         else if (wr_en && bus_addr == ADR_CLEAR && bus_wdata[f])
            flags[f] <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADR_CTRL: begin
            bus_rdata[CTRL_EN]    = enable;
            bus_rdata[CTRL_START] = run;
         end
         ADR_SHAPE: begin
            bus_rdata[PRESC_W-1:0] = presc;
            bus_rdata[POL_BIT]     = pol;
         end
         ADR_RELOAD: bus_rdata[CNT_W-1:0]  = reload_sh;
         ADR_CMP:    bus_rdata[CNT_W-1:0]  = cmp_sh;
         ADR_FLAGS:  bus_rdata[NFLAGS-1:0] = flags;
         default:    bus_rdata = '0;
      endcase
   end

   // R3
   a_r3_shape_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bus_addr == ADR_SHAPE && enable) |=> ($stable(presc) && $stable(pol)));
   // R4
   a_r4_reload_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bus_addr == ADR_RELOAD && !enable) |=> $stable(reload_sh));
   // R7
   a_r7_run_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> enable);
   // R12
   a_r12_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bus_addr == ADR_CTRL && !bus_wdata[CTRL_EN]) |=> (!enable && !run));
endmodule

// File: rtl/lpt_prescaler.sv
module lpt_prescaler #(
   parameter int PRESC_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [PRESC_W-1:0] presc,
   output logic               tick
);
   localparam int DIV_W = (1 << PRESC_W) - 1;

   if (PRESC_W < 1 || PRESC_W > 4) begin : g_bad_presc
      $error("PRESC_W must be between 1 and 4");
   end

   logic [DIV_W-1:0] divcnt;
   logic [DIV_W-1:0] mask;

   assign mask = ~({DIV_W{1'b1}} << presc);
   assign tick = run && ((divcnt & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   divcnt <= '0;
      else if (run) divcnt <= divcnt + 1'b1;
      else          divcnt <= '0;
   end

   // R9
   a_r9_no_division: assert property (@(posedge clk) disable iff (!rst_n)
      (run && presc == '0) |-> tick);
endmodule

// File: rtl/lpt_counter.sv
module lpt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             pol,
   input  logic [CNT_W-1:0] reload_sh,
   input  logic [CNT_W-1:0] cmp_sh,
   output logic             pwm_out
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] reload_act;
   logic [CNT_W-1:0] cmp_act;
   logic             at_top;

   assign at_top = (cnt >= reload_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         reload_act <= '0;
         cmp_act    <= '0;
      end else if (!run) begin
         cnt        <= '0;
         reload_act <= reload_sh;
         cmp_act    <= cmp_sh;
      end else if (tick) begin
         if (at_top) begin
            cnt        <= '0;
            reload_act <= reload_sh;
            cmp_act    <= cmp_sh;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign pwm_out = pol ^ (run && (cnt > cmp_act));

   // R8
   a_r8_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= reload_act);
   // R8
   a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && cnt == reload_act) |=> (cnt == '0));
   // R10
   a_r10_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (pwm_out == pol));
endmodule

// File: rtl/lpt_pwm_timer.sv
module lpt_pwm_timer
   import lpt_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 16,
   parameter int PRESC_W     = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              pwm_out
);
   if (CNT_W > DATA_W) begin : g_bad_width
      $error("CNT_W must not exceed DATA_W");
   end

   logic               enable;
   logic               run;
   logic [PRESC_W-1:0] presc;
   logic               pol;
   logic [CNT_W-1:0]   reload_sh;
   logic [CNT_W-1:0]   cmp_sh;
   logic               tick;

   lpt_regs #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .PRESC_W(PRESC_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .enable(enable), .run(run), .presc(presc), .pol(pol),
      .reload_sh(reload_sh), .cmp_sh(cmp_sh)
   );

   lpt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .run(run), .presc(presc), .tick(tick)
   );

   lpt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .pol(pol),
      .reload_sh(reload_sh), .cmp_sh(cmp_sh), .pwm_out(pwm_out)
   );
endmodule

// File: tb/lpt_pwm_timer_tb.sv
module lpt_pwm_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        pwm_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   lpt_pwm_timer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pwm_out(pwm_out)
   );

   // {prescale(3), polarity(1), reload(16), compare(16), expected active samples(16)}
   localparam int NV = 9;
   localparam logic [51:0] VEC [NV] = '{
      {3'd0, 1'b0, 16'd9, 16'd4, 16'd10},
      {3'd0, 1'b0, 16'd7, 16'd1, 16'd12},
      {3'd2, 1'b0, 16'd3, 16'd0, 16'd24},
      {3'd1, 1'b1, 16'd5, 16'd3, 16'd16},
      {3'd0, 1'b0, 16'd4, 16'd4, 16'd0},
      {3'd0, 1'b0, 16'd6, 16'd9, 16'd0},
      {3'd3, 1'b0, 16'd1, 16'd0, 16'd16},
      {3'd7, 1'b0, 16'd1, 16'd0, 16'd256},
      {3'd0, 1'b1, 16'd0, 16'd0, 16'd2}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      bus_addr = a;
      #1;
      v = int'(bus_rdata);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), v);
         chk("R1 register reset", v, 0);
      end
      chk("R1 output reset", int'(pwm_out), 0);

      // R7 start without enable
      wr(3'd0, 16'h0002);
      rd(3'd0, v); chk("R7 start ignored when disabled", v, 0);

      // R4 reload while disabled
      wr(3'd2, 16'd9);
      rd(3'd2, v); chk("R4 reload ignored", v, 0);
      repeat (3) @(negedge clk);
      rd(3'd4, v); chk("R4 no flag", v, 0);

      // R2 / R3 shape register
      wr(3'd1, 16'h0009);
      rd(3'd1, v); chk("R2 shape readback", v, 9);
      wr(3'd0, 16'h0001);
      rd(3'd0, v); chk("R2 control readback", v, 1);
      wr(3'd1, 16'h0002);
      rd(3'd1, v); chk("R3 shape locked", v, 9);
      chk("R10 idle level inverted", int'(pwm_out), 1);

      // R5 flag timing
      wr(3'd2, 16'd5);
      rd(3'd4, v); chk("R5 flag not after first edge", v, 0);
      @(negedge clk);
      rd(3'd4, v); chk("R5 flag not after second edge", v, 0);
      @(negedge clk);
      rd(3'd4, v); chk("R5 reload flag set", v, 1);
      rd(3'd2, v); chk("R2 reload readback", v, 5);
      wr(3'd3, 16'd2);
      repeat (2) @(negedge clk);
      rd(3'd4, v); chk("R5 both flags", v, 3);

      // R6 clear
      wr(3'd5, 16'h0001);
      rd(3'd4, v); chk("R6 clear reload flag only", v, 2);
      wr(3'd5, 16'h0002);
      rd(3'd4, v); chk("R6 clear compare flag", v, 0);

      // R12 stop
      wr(3'd0, 16'h0003);
      rd(3'd0, v); chk("R7 running readback", v, 3);
      wr(3'd0, 16'h0000);
      rd(3'd0, v); chk("R12 control cleared", v, 0);
      chk("R12 output at polarity", int'(pwm_out), 1);
      wr(3'd1, 16'h0000);

      // R8 R9 R10 vector table
      for (int i = 0; i < NV; i++) begin
         logic [2:0]  pr;
         logic        pl;
         logic [15:0] rl, cp, ex;
         int          win, high;
         {pr, pl, rl, cp, ex} = VEC[i];
         win = (2 * (int'(rl) + 1)) << pr;
         wr(3'd0, 16'h0000);
         wr(3'd1, {12'd0, pl, pr});
         wr(3'd0, 16'h0001);
         wr(3'd2, rl);
         wr(3'd3, cp);
         wr(3'd0, 16'h0003);
         high = 0;
         for (int s = 0; s < win; s++) begin
            high += int'(pwm_out);
            @(negedge clk);
         end
         chk($sformatf("R8 R9 R10 vector %0d active count", i), high, int'(ex));
      end
      wr(3'd0, 16'h0000);
      wr(3'd1, 16'h0000);

      // R11 deferred compare update
      wr(3'd0, 16'h0001);
      wr(3'd2, 16'd15);
      wr(3'd3, 16'd0);
      wr(3'd0, 16'h0003);
      wr(3'd3, 16'd15);
      chk("R11 old compare still applies", int'(pwm_out), 1);
      repeat (20) @(negedge clk);
      begin
         int high = 0;
         for (int s = 0; s < 16; s++) begin
            high += int'(pwm_out);
            @(negedge clk);
         end
         chk("R11 new compare after wrap", high, 0);
      end

      // R12 stop while running
      wr(3'd3, 16'd0);
      repeat (40) @(negedge clk);
      wr(3'd0, 16'h0000);
      chk("R12 output inactive after stop", int'(pwm_out), 0);
      rd(3'd0, v); chk("R12 stopped readback", v, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule